// File: doc/BRIEF.md
# Linked-list scatter/gather DMA engine

This block is a single-channel DMA engine that copies word data from memory to a fixed peripheral address. It does not take one flat transfer. It walks a chain of four-word descriptors held in memory. Each descriptor names a source address, a destination address, the address of the next descriptor and a control word. The control word carries the word count, the address-increment selects and a terminal-count interrupt enable. Software loads the first descriptor into the channel registers and sets the enable bit. From then on, the engine reloads its own registers from memory until it meets a descriptor whose next pointer is zero.

Data moves in bursts of up to `BURST` words. The engine reads a burst into a local buffer and then writes the buffer out in the same order. When the count is not a multiple of `BURST`, the block ends with a shorter burst. A single memory-mapped master port, with a request and acknowledge handshake, carries all descriptor reads, data reads and data writes. Each descriptor may raise a sticky interrupt when its block ends. Software clears that interrupt through a separate clear register.

The sequencer has five states:
- `ST_IDLE` waits for a start.
- `ST_READ` fills the burst buffer.
- `ST_WRITE` drains the buffer to the destination.
- `ST_BLKEND` closes a block, raises the interrupt if it is enabled and checks the next pointer.
- `ST_FETCH` reads the four words of the next descriptor.

The transitions are:
- IDLE to READ on a start with a nonzero count, and IDLE to BLKEND on a start with a zero count.
- READ to WRITE when the last word of the burst is acknowledged.
- WRITE to READ when the burst ends and words remain, and WRITE to BLKEND when the last word of the block is written.
- BLKEND to IDLE when the next pointer is zero, and BLKEND to FETCH otherwise.
- FETCH to READ after the fourth word, or FETCH to BLKEND if the fetched count is zero.

Top module: `sg_dma_chain`

## Requirements
- R1: While reset is held, and just after it is released, `busy`, `tc_irq` and `m_req` are all low.
- R2: When idle, a write of 1 to bit 0 of the enable register (select 4) starts the channel. The channel uses the register values at select 0 (source), 1 (destination), 2 (next pointer) and 3 (control), and `busy` is high in the cycle after the write.
- R3: The control word bits [11:0] give the block length in 32-bit words. Each block is moved as bursts of up to 16 reads followed by the same number of writes, in order. A length that is not a multiple of 16 ends with a partial burst, and a 768-word (3072-byte) block is supported.
- R4: Control bit 26 set makes the source address advance by 4 after each word, and clear holds it fixed. Control bit 27 does the same for the destination address.
- R5: When a block ends and the next pointer is nonzero, the engine reads four words at next, next+4, next+8 and next+12. It loads them as source, destination, next pointer and control, in that order, before it issues any data access of the new block.
- R6: When a block ends and the next pointer is zero, `busy` drops and no further master requests are made.
- R7: A descriptor with a length of zero moves no data, but it still ends normally: the interrupt follows R8 and the chain follows R5 or R6.
- R8: If control bit 31 is set, `tc_irq` rises at the end of that descriptor's block. If the bit is clear, the block raises no interrupt.
- R9: `tc_irq` stays high until a write to the clear register (select 5) has bit 0 set. A clear write with bit 0 at zero leaves it set.
- R10: Writes to selects 0 to 4 while the channel is busy are ignored. The transfer in progress and its result do not change.
- R11: `m_req` stays high with a stable address and direction until `m_ack`, and each acknowledge completes exactly one word access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 src, 1 dst, 2 next, 3 control, 4 enable, 5 interrupt clear |
| cfg_wdata | input | 32 | Register write data |
| m_req | output | 1 | Master access request |
| m_we | output | 1 | Master access is a write |
| m_addr | output | 32 | Master byte address |
| m_wdata | output | 32 | Master write data |
| m_rdata | input | 32 | Master read data, valid with m_ack on reads |
| m_ack | input | 1 | Master access complete |
| busy | output | 1 | Channel active |
| tc_irq | output | 1 | Terminal-count interrupt pending |

## Verification
The bench builds the engine with its default `BURST` of 16 and `CNT_W` of 12. With these values a single descriptor can carry the full 768-word block, which is 48 full bursts, alongside counts of 0, 5, 16, 20 and 37. Those counts exercise the exact-fit, partial-only and full-plus-partial burst endings. A 16-entry buffer with a bench memory that acknowledges every other cycle makes chains of one to four descriptors short enough to check word by word against the source pattern and destination addresses. The same settings allow mid-transfer register writes and sticky-interrupt checks.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

    localparam logic [2:0] SEL_SRC  = 3'd0;
    localparam logic [2:0] SEL_DST  = 3'd1;
    localparam logic [2:0] SEL_NEXT = 3'd2;
    localparam logic [2:0] SEL_CTRL = 3'd3;
    localparam logic [2:0] SEL_EN   = 3'd4;
    localparam logic [2:0] SEL_CLR  = 3'd5;

    localparam int CTL_SINC = 26;
    localparam int CTL_DINC = 27;
    localparam int CTL_TC   = 31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_BLKEND,
        ST_FETCH
    } seq_state_t;

endpackage

// File: rtl/sgdma_burst_buf.sv
module sgdma_burst_buf #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] widx,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0] ridx,
    output logic [W-1:0]             rdata
);
    logic [W-1:0] slot [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            slot[widx] <= wdata;
        end
    end

    assign rdata = slot[ridx];
endmodule

// File: rtl/sgdma_chan.sv
module sgdma_chan
    import sgdma_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [2:0]       cfg_sel,
    input  logic [31:0]      cfg_wdata,
    input  logic             busy,
    input  logic             ld_en,
    input  logic [1:0]       ld_idx,
    input  logic [31:0]      ld_data,
    input  logic             src_step,
    input  logic             dst_step,
    input  logic             cnt_dec,
    input  logic             set_tc,
    output logic [31:0]      src,
    output logic [31:0]      dst,
    output logic [31:0]      nxt,
    output logic [CNT_W-1:0] cnt,
    output logic             tc_en,
    output logic             tc_pend
);
    logic sinc_q, dinc_q;
    logic wr_ok, clr;

    assign wr_ok = cfg_wr && !busy;
    assign clr   = cfg_wr && (cfg_sel == SEL_CLR) && cfg_wdata[0];

    // Channel registers: loaded by software when idle, by descriptor fetch when busy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src    <= '0;
            dst    <= '0;
            nxt    <= '0;
            cnt    <= '0;
            tc_en  <= 1'b0;
            sinc_q <= 1'b0;
            dinc_q <= 1'b0;
        end else begin
            if (ld_en) begin
                unique case (ld_idx)
                    2'd0: src <= ld_data;
                    2'd1: dst <= ld_data;
                    2'd2: nxt <= ld_data;
                    default: begin
                        cnt    <= ld_data[CNT_W-1:0];
                        tc_en  <= ld_data[CTL_TC];
                        sinc_q <= ld_data[CTL_SINC];
                        dinc_q <= ld_data[CTL_DINC];
                    end
                endcase
            end else if (wr_ok) begin
                if (cfg_sel == SEL_SRC)  src <= cfg_wdata;
                if (cfg_sel == SEL_DST)  dst <= cfg_wdata;
                if (cfg_sel == SEL_NEXT) nxt <= cfg_wdata;
                if (cfg_sel == SEL_CTRL) begin
                    cnt    <= cfg_wdata[CNT_W-1:0];
                    tc_en  <= cfg_wdata[CTL_TC];
                    sinc_q <= cfg_wdata[CTL_SINC];
                    dinc_q <= cfg_wdata[CTL_DINC];
                end
            end
            if (src_step && sinc_q) src <= src + 32'd4;
            if (dst_step && dinc_q) dst <= dst + 32'd4;
            if (cnt_dec)            cnt <= cnt - CNT_W'(1);
        end
    end

    // Sticky terminal-count flag; a new block end wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_pend <= 1'b0;
        end else if (set_tc) begin
            tc_pend <= 1'b1;
        end else if (clr) begin
            tc_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/sgdma_seq.sv
module sgdma_seq
    import sgdma_pkg::*;
#(
    parameter int BURST = 16,
    parameter int CNT_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [CNT_W-1:0]         cnt,
    input  logic [31:0]              src,
    input  logic [31:0]              dst,
    input  logic [31:0]              nxt,
    input  logic                     tc_en,
    input  logic                     m_ack,
    input  logic                     fetch_cnt_zero,
    output logic                     m_req,
    output logic                     m_we,
    output logic [31:0]              m_addr,
    output logic [$clog2(BURST)-1:0] beat,
    output logic                     buf_we,
    output logic                     src_step,
    output logic                     dst_step,
    output logic                     cnt_dec,
    output logic                     ld_en,
    output logic [1:0]               ld_idx,
    output logic                     set_tc,
    output logic                     busy,
    output logic                     fetching
);
    localparam int IW = $clog2(BURST);
    localparam int BW = $clog2(BURST + 1);

    seq_state_t     st_q, st_d;
    logic [IW-1:0]  beat_q;
    logic [BW-1:0]  blen_q, blen_now;
    logic [31:0]    fbase_q;
    logic           rd_last, wr_last, fetch_last;

    assign blen_now   = (cnt >= CNT_W'(BURST)) ? BW'(BURST) : BW'(cnt);
    assign rd_last    = (BW'(beat_q) == blen_now - BW'(1));
    assign wr_last    = (BW'(beat_q) == blen_q - BW'(1));
    assign fetch_last = (beat_q == IW'(3));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start) st_d = (cnt == '0) ? ST_BLKEND : ST_READ;
            ST_READ:   if (m_ack && rd_last) st_d = ST_WRITE;
            ST_WRITE:  if (m_ack && wr_last) st_d = (cnt == CNT_W'(1)) ? ST_BLKEND : ST_READ;
            ST_BLKEND: st_d = (nxt == '0) ? ST_IDLE : ST_FETCH;
            ST_FETCH:  if (m_ack && fetch_last) st_d = fetch_cnt_zero ? ST_BLKEND : ST_READ;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Beat/word index, latched burst length and descriptor fetch base
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q  <= '0;
            blen_q  <= '0;
            fbase_q <= '0;
        end else begin
            if (st_d != st_q)        beat_q <= '0;
            else if (m_req && m_ack) beat_q <= beat_q + IW'(1);
            if (st_q == ST_READ && st_d == ST_WRITE) blen_q <= blen_now;
            if (st_q == ST_BLKEND) fbase_q <= nxt;
        end
    end

    always_comb begin
        m_req    = 1'b0;
        m_we     = 1'b0;
        m_addr   = '0;
        buf_we   = 1'b0;
        src_step = 1'b0;
        dst_step = 1'b0;
        cnt_dec  = 1'b0;
        ld_en    = 1'b0;
        set_tc   = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_READ: begin
                m_req    = 1'b1;
                m_addr   = src;
                buf_we   = m_ack;
                src_step = m_ack;
            end
            ST_WRITE: begin
                m_req    = 1'b1;
                m_we     = 1'b1;
                m_addr   = dst;
                dst_step = m_ack;
                cnt_dec  = m_ack;
            end
            ST_BLKEND: set_tc = tc_en;
            ST_FETCH: begin
                m_req  = 1'b1;
                m_addr = fbase_q + 32'({beat_q[1:0], 2'b00});
                ld_en  = m_ack;
            end
            default: ;
        endcase
    end

    assign beat     = beat_q;
    assign ld_idx   = beat_q[1:0];
    assign busy     = (st_q != ST_IDLE);
    assign fetching = (st_q == ST_FETCH);
endmodule

// File: rtl/sg_dma_chain.sv
module sg_dma_chain
    import sgdma_pkg::*;
#(
    parameter int BURST = 16,
    parameter int CNT_W = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [2:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic        m_req,
    output logic        m_we,
    output logic [31:0] m_addr,
    output logic [31:0] m_wdata,
    input  logic [31:0] m_rdata,
    input  logic        m_ack,
    output logic        busy,
    output logic        tc_irq
);
    localparam int IW = $clog2(BURST);

    logic [31:0]      src, dst, nxt;
    logic [CNT_W-1:0] cnt;
    logic             tc_en, start, fetch_cnt_zero;
    logic [IW-1:0]    beat;
    logic             buf_we, src_step, dst_step, cnt_dec, ld_en, set_tc, fetching;
    logic [1:0]       ld_idx;

    assign start          = cfg_wr && (cfg_sel == SEL_EN) && cfg_wdata[0];
    assign fetch_cnt_zero = (m_rdata[CNT_W-1:0] == '0);

    sgdma_chan #(.CNT_W(CNT_W)) u_chan (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .busy(busy), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(m_rdata),
        .src_step(src_step), .dst_step(dst_step), .cnt_dec(cnt_dec), .set_tc(set_tc),
        .src(src), .dst(dst), .nxt(nxt), .cnt(cnt), .tc_en(tc_en), .tc_pend(tc_irq)
    );

    sgdma_seq #(.BURST(BURST), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cnt(cnt), .src(src), .dst(dst), .nxt(nxt), .tc_en(tc_en),
        .m_ack(m_ack), .fetch_cnt_zero(fetch_cnt_zero),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .beat(beat),
        .buf_we(buf_we), .src_step(src_step), .dst_step(dst_step), .cnt_dec(cnt_dec),
        .ld_en(ld_en), .ld_idx(ld_idx), .set_tc(set_tc), .busy(busy), .fetching(fetching)
    );

    sgdma_burst_buf #(.W(32), .DEPTH(BURST)) u_buf (
        .clk(clk), .we(buf_we), .widx(beat), .wdata(m_rdata),
        .ridx(beat), .rdata(m_wdata)
    );
endmodule

// File: rtl/sgdma_chain_chk.sv
module sgdma_chain_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic [2:0]  cfg_sel,
    input logic        wdata0,
    input logic        m_req,
    input logic        m_we,
    input logic        m_ack,
    input logic [31:0] m_addr,
    input logic        busy,
    input logic        tc_irq,
    input logic        fetching
);
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !m_req); // R6
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel == 3'd4 && wdata0 && !busy) |=> busy); // R2
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we))); // R11
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_irq && !(cfg_wr && cfg_sel == 3'd5 && wdata0)) |=> tc_irq); // R9
    AST_FETCH_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (fetching && $past(fetching) && $past(m_ack)) |-> (m_addr == $past(m_addr) + 32'd4)); // R5
    AST_FETCH_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (fetching && m_req) |-> !m_we); // R5
endmodule

bind sg_dma_chain sgdma_chain_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .wdata0(cfg_wdata[0]),
    .m_req(m_req), .m_we(m_we), .m_ack(m_ack), .m_addr(m_addr),
    .busy(busy), .tc_irq(tc_irq), .fetching(fetching)
);

// File: tb/sim_sg_dma_chain.sv
module sim_sg_dma_chain;
    localparam logic [31:0] PERIPH = 32'h8000_0000;
    localparam int MEMW = 8192;
    // {ndesc[17:15], count[14:3], tc[2], sinc[1], dinc[0]}
    localparam logic [17:0] VEC [6] = '{
        {3'd1, 12'd5,   1'b1, 1'b1, 1'b0},
        {3'd2, 12'd16,  1'b0, 1'b1, 1'b0},
        {3'd3, 12'd37,  1'b1, 1'b0, 1'b0},
        {3'd2, 12'd20,  1'b0, 1'b1, 1'b1},
        {3'd4, 12'd768, 1'b1, 1'b1, 1'b0},
        {3'd1, 12'd0,   1'b1, 1'b1, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic m_req, m_we, m_ack, busy, tc_irq;
    logic [31:0] m_addr, m_wdata, m_rdata;

    logic [31:0] mem [MEMW];
    logic [31:0] log_a [MEMW];
    logic [31:0] log_d [MEMW];
    int wr_n = 0, rd_n = 0;
    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sg_dma_chain u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .m_ack(m_ack), .busy(busy), .tc_irq(tc_irq)
    );

    // Memory model: one wait cycle per access, logs every write and counts reads
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ack   <= 1'b0;
            m_rdata <= '0;
        end else begin
            if (m_req && !m_ack) begin
                m_ack <= 1'b1;
                if (!m_we) m_rdata <= mem[m_addr[14:2]];
            end else begin
                m_ack <= 1'b0;
            end
            if (m_req && m_ack && m_we) begin
                if (wr_n < MEMW) begin
                    log_a[wr_n] <= m_addr;
                    log_d[wr_n] <= m_wdata;
                end
                wr_n <= wr_n + 1;
            end
            if (m_req && m_ack && !m_we) rd_n <= rd_n + 1;
        end
    end

    function automatic logic [31:0] pat(int w);
        return (32'(w) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [31:0] mkctl(int cnt, bit tc, bit sinc, bit dinc);
        return {tc, 3'b000, dinc, sinc, 14'd0, 12'(cnt)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic build_chain(input int n, input int cnt, input bit tc, input bit sinc, input bit dinc);
        for (int i = 0; i < n; i++) begin
            mem[64 + 4*i]     = 32'h1000 * (i + 1);
            mem[64 + 4*i + 1] = PERIPH;
            mem[64 + 4*i + 2] = (i == n - 1) ? 32'h0 : 32'h100 + 32'(16 * (i + 1));
            mem[64 + 4*i + 3] = mkctl(cnt, tc, sinc, dinc);
        end
    endtask

    task automatic start_chain();
        cfg_write(3'd0, mem[64]);
        cfg_write(3'd1, mem[65]);
        cfg_write(3'd2, mem[66]);
        cfg_write(3'd3, mem[67]);
        cfg_write(3'd4, 32'h1);
    endtask

    task automatic run_wait(input bit auto_clr, output int irqs);
        irqs = 0;
        forever begin
            @(negedge clk);
            if (auto_clr && tc_irq) begin
                irqs++;
                cfg_wr = 1'b1; cfg_sel = 3'd5; cfg_wdata = 32'h1;
                @(negedge clk);
                cfg_wr = 1'b0;
            end
            if (!busy) break;
        end
    endtask

    // Compare the logged write stream against the source pattern
    task automatic check_stream(input int base, input int n, input int cnt, input bit sinc,
                                input bit dinc, input int blk0, input string tag);
        int bad = 0;
        logic [31:0] fa = '0, fe = '0;
        for (int b = 0; b < n; b++) begin
            for (int j = 0; j < cnt; j++) begin
                int k = base + b*cnt + j;
                int sw = ((blk0 + 32'h1000 * b) >> 2) + (sinc ? j : 0);
                logic [31:0] ea = PERIPH + (dinc ? 32'(4*j) : 32'h0);
                if (log_d[k] !== pat(sw) || log_a[k] !== ea) begin
                    if (bad == 0) begin fa = log_d[k]; fe = pat(sw); end
                    bad++;
                end
            end
        end
        chk(bad == 0, tag, fa, fe);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base, rbase, irqs, n, cnt;
        bit tc, sinc, dinc;
        for (int i = 0; i < MEMW; i++) mem[i] = pat(i);
        repeat (3) @(negedge clk);
        chk(!busy && !tc_irq && !m_req, "R1 reset outputs", {busy, tc_irq, m_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !tc_irq && !m_req, "R1 after release", {busy, tc_irq, m_req}, 0);

        foreach (VEC[e]) begin
            n = int'(VEC[e][17:15]); cnt = int'(VEC[e][14:3]);
            tc = VEC[e][2]; sinc = VEC[e][1]; dinc = VEC[e][0];
            build_chain(n, cnt, tc, sinc, dinc);
            base = wr_n; rbase = rd_n;
            start_chain();
            chk(busy, "R2 busy after start", 32'(busy), 1);
            run_wait(1'b1, irqs);
            chk(wr_n - base == n * cnt, "R3 R7 write count", wr_n - base, n * cnt);
            check_stream(base, n, cnt, sinc, dinc, 32'h1000, "R3 R4 R5 stream data/addr");
            chk(rd_n - rbase == n*cnt + 4*(n-1), "R5 R11 read count", rd_n - rbase, n*cnt + 4*(n-1));
            chk(irqs == (tc ? n : 0), "R8 interrupt count", irqs, tc ? n : 0);
            repeat (4) @(negedge clk);
            chk(!busy && !m_req && !tc_irq, "R6 idle after null next", {busy, m_req, tc_irq}, 0);
        end

        // R9: pending persists until a clear write with bit 0 set
        build_chain(1, 3, 1'b1, 1'b1, 1'b0);
        start_chain();
        run_wait(1'b0, irqs);
        repeat (30) @(negedge clk);
        chk(tc_irq, "R9 interrupt stays pending", 32'(tc_irq), 1);
        cfg_write(3'd5, 32'h0);
        chk(tc_irq, "R9 clear with bit0 zero", 32'(tc_irq), 1);
        cfg_write(3'd5, 32'h1);
        chk(!tc_irq, "R9 clear with bit0 set", 32'(tc_irq), 0);

        // R10: register and enable writes while busy are ignored
        build_chain(1, 40, 1'b0, 1'b1, 1'b0);
        base = wr_n;
        start_chain();
        repeat (6) @(negedge clk);
        cfg_write(3'd0, 32'h6000);
        cfg_write(3'd3, mkctl(1, 1'b1, 1'b0, 1'b0));
        cfg_write(3'd4, 32'h1);
        run_wait(1'b1, irqs);
        chk(wr_n - base == 40, "R10 write count unchanged", wr_n - base, 40);
        check_stream(base, 1, 40, 1'b1, 1'b0, 32'h1000, "R10 data unchanged");
        chk(irqs == 0, "R10 interrupt enable unchanged", irqs, 0);
        @(negedge clk);
        chk(!busy, "R10 no restart", 32'(busy), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule